// File: doc/BRIEF.md
# Program Counter with Latched Upper Bytes

This block holds the 21-bit byte address of the next instruction fetch for a small processor core. The counter is split into a low byte, a high byte (bits 15:8) and a 5-bit upper part (bits 20:16). Software can reach only the low byte directly. The high and upper parts are staged in two holding latch registers and take effect together with a write of the low byte. A read of the low byte refreshes both latches from the live counter, which gives code a consistent 21-bit snapshot for computed jumps.

The core's sequencer drives the other update sources as plain strobes:
- a sequential advance, which adds 2;
- a direct jump, call or branch load with a full 21-bit target;
- a return load carrying the popped address;
- an interrupt acknowledge, which selects one of two fixed vectors.

None of these loads touches the holding latches. Every interface is a single-cycle strobe or level, and there is no streaming data path. Bit 0 of the counter is always zero, so fetches stay halfword aligned.

Top module: `pc_latched_upper`

## Requirements
- R1: An asynchronous active-low reset sets the fetch address to 0x000000 and clears both holding latches. While reset is held, the reset wins over every other source.
- R2: An advance strobe with no higher-priority source active adds 2 to the fetch address, modulo 2^21, so 0x1FFFFE advances to 0x000000.
- R3: A jump load (jmp_load_i) sets the fetch address to jmp_target_i with bit 0 cleared. A jump load leaves both holding latches unchanged.
- R4: A return load (ret_load_i) sets the fetch address to ret_addr_i with bit 0 cleared and leaves the holding latches unchanged. When a jump load and a return load are both active, the jump load wins.
- R5: An interrupt acknowledge loads 0x000008 when irq_hi_i is 1 and 0x000018 when irq_hi_i is 0.
- R6: A register write with reg_sel_i = 2'b00 (low byte) sets the fetch address to {upper latch, high latch, reg_wdata_i[7:1], 0}.
- R7: A register read with reg_sel_i = 2'b00 returns fetch address bits [7:0] on reg_rdata_o. At the clock edge it copies the pre-edge fetch bits [15:8] into the high latch and bits [20:16] into the upper latch.
- R8: reg_sel_i = 2'b01 selects the high latch and 2'b10 selects the upper latch, for both writes and reads. The upper latch stores reg_wdata_i[4:0] and reads back with bits [7:5] as 0. reg_sel_i = 2'b11 reads 0 and its writes have no effect.
- R9: Priority per cycle is: reset, then interrupt acknowledge, then jump or return load, then low-byte write, then advance. A low-byte write that loses to a higher-priority source is dropped entirely.
- R10: Bit 0 of the fetch address is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Sequential advance strobe |
| jmp_load_i | input | 1 | Jump/call/branch load strobe |
| jmp_target_i | input | 21 | Jump/call/branch target address |
| ret_load_i | input | 1 | Return load strobe |
| ret_addr_i | input | 21 | Popped return address |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_hi_i | input | 1 | 1 selects the high-priority vector, 0 the low one |
| reg_sel_i | input | 2 | Register select: 00 low byte, 01 high latch, 10 upper latch, 11 none |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| fetch_addr_o | output | 21 | Current fetch address |
| reg_rdata_o | output | 8 | Register read data for the selected register |

## Verification
Two functions can fall in the same cycle:
- A low-byte write can coincide with a jump load. The bench drives both strobes in one cycle. It then expects the jump target and latches that still hold their staged values, which proves the write was dropped rather than merged.
- A low-byte read snapshot can coincide with an advance that carries into bit 8. The bench starts this case at 0x02FFFE and expects the latches to hold the pre-edge upper bits, 0xFF and 0x02, while the counter moves to 0x030000.

Interrupt over jump, and jump over return, are also driven together and judged by the resulting fetch address.

// File: rtl/pc_latch_pkg.sv
package pc_latch_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD  = 3'd0,
    SRC_ADV   = 3'd1,
    SRC_LOWWR = 3'd2,
    SRC_LOAD  = 3'd3,
    SRC_VEC   = 3'd4
  } pc_src_e;

  typedef enum logic [1:0] {
    REG_LOW   = 2'b00,
    REG_HIGH  = 2'b01,
    REG_UPPER = 2'b10,
    REG_NONE  = 2'b11
  } reg_sel_e;

endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_latch_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8,
  parameter int STEP   = 2,
  parameter int VEC_HI = 8,
  parameter int VEC_LO = 24,
  localparam int UP_W  = ADDR_W - 2 * BYTE_W
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              adv_i,
  input  logic              jmp_i,
  input  logic [ADDR_W-1:0] jmp_tgt_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              irq_i,
  input  logic              irq_hi_i,
  input  logic              low_wr_i,
  input  logic [BYTE_W-1:0] low_data_i,
  input  logic [BYTE_W-1:0] hold_hi_i,
  input  logic [UP_W-1:0]   hold_up_i,
  output logic [ADDR_W-1:0] nxt_o,
  output pc_src_e           src_o
);

  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] composed;

  // Low-byte write merges staged latches with the written byte.
  assign composed = {hold_up_i, hold_hi_i, low_data_i};

  always_comb begin
    src_o = SRC_HOLD;
    raw   = cur_i;
    if (irq_i) begin
      src_o = SRC_VEC;
      raw   = irq_hi_i ? ADDR_W'(VEC_HI) : ADDR_W'(VEC_LO);
    end else if (jmp_i) begin
      src_o = SRC_LOAD;
      raw   = jmp_tgt_i;
    end else if (ret_i) begin
      src_o = SRC_LOAD;
      raw   = ret_addr_i;
    end else if (low_wr_i) begin
      src_o = SRC_LOWWR;
      raw   = composed;
    end else if (adv_i) begin
      src_o = SRC_ADV;
      raw   = cur_i + ADDR_W'(STEP);
    end
  end

  // Halfword alignment: bit 0 never set.
  assign nxt_o = {raw[ADDR_W-1:1], 1'b0};

endmodule

// File: rtl/pc_hold_latches.sv
module pc_hold_latches #(
  parameter int BYTE_W = 8,
  parameter int UP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi_i,
  input  logic              wr_up_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] snap_hi_i,
  input  logic [UP_W-1:0]   snap_up_i,
  output logic [BYTE_W-1:0] hold_hi_o,
  output logic [UP_W-1:0]   hold_up_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi_o <= '0;
    end else if (wr_hi_i) begin
      hold_hi_o <= wdata_i;
    end else if (snap_i) begin
      hold_hi_o <= snap_hi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_up_o <= '0;
    end else if (wr_up_i) begin
      hold_up_o <= wdata_i[UP_W-1:0];
    end else if (snap_i) begin
      hold_up_o <= snap_up_i;
    end
  end

endmodule

// File: rtl/pc_readback.sv
module pc_readback
  import pc_latch_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int UP_W   = 5
) (
  input  reg_sel_e          sel_i,
  input  logic [BYTE_W-1:0] pc_low_i,
  input  logic [BYTE_W-1:0] hold_hi_i,
  input  logic [UP_W-1:0]   hold_up_i,
  output logic [BYTE_W-1:0] rdata_o
);

  logic [BYTE_W-1:0] up_wide;

  generate
    if (UP_W < BYTE_W) begin : g_pad
      assign up_wide = {{(BYTE_W - UP_W){1'b0}}, hold_up_i};
    end else begin : g_full
      assign up_wide = hold_up_i[BYTE_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      REG_LOW:   rdata_o = pc_low_i;
      REG_HIGH:  rdata_o = hold_hi_i;
      REG_UPPER: rdata_o = up_wide;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pc_latched_upper.sv
module pc_latched_upper
  import pc_latch_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8,
  parameter int STEP   = 2,
  parameter int VEC_HI = 8,
  parameter int VEC_LO = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              jmp_load_i,
  input  logic [20:0]       jmp_target_i,
  input  logic              ret_load_i,
  input  logic [20:0]       ret_addr_i,
  input  logic              irq_ack_i,
  input  logic              irq_hi_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [20:0]       fetch_addr_o,
  output logic [7:0]        reg_rdata_o
);

  localparam int UP_W = ADDR_W - 2 * BYTE_W;
  localparam int HI_L = BYTE_W;
  localparam int HI_H = 2 * BYTE_W - 1;

  reg_sel_e          sel;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  pc_src_e           src;
  logic [BYTE_W-1:0] hold_hi;
  logic [UP_W-1:0]   hold_up;
  logic              low_wr;
  logic              low_rd;

  assign sel    = reg_sel_e'(reg_sel_i);
  assign low_wr = reg_wr_i && (sel == REG_LOW);
  assign low_rd = reg_rd_i && (sel == REG_LOW);

  pc_next_sel #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STEP(STEP),
    .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
  ) u_next (
    .cur_i      (pc_q),
    .adv_i      (adv_i),
    .jmp_i      (jmp_load_i),
    .jmp_tgt_i  (jmp_target_i),
    .ret_i      (ret_load_i),
    .ret_addr_i (ret_addr_i),
    .irq_i      (irq_ack_i),
    .irq_hi_i   (irq_hi_i),
    .low_wr_i   (low_wr),
    .low_data_i (reg_wdata_i),
    .hold_hi_i  (hold_hi),
    .hold_up_i  (hold_up),
    .nxt_o      (pc_d),
    .src_o      (src)
  );

  pc_hold_latches #(.BYTE_W(BYTE_W), .UP_W(UP_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hi_i   (reg_wr_i && (sel == REG_HIGH)),
    .wr_up_i   (reg_wr_i && (sel == REG_UPPER)),
    .wdata_i   (reg_wdata_i),
    .snap_i    (low_rd),
    .snap_hi_i (pc_q[HI_H:HI_L]),
    .snap_up_i (pc_q[ADDR_W-1:HI_H+1]),
    .hold_hi_o (hold_hi),
    .hold_up_o (hold_up)
  );

  pc_readback #(.BYTE_W(BYTE_W), .UP_W(UP_W)) u_rb (
    .sel_i     (sel),
    .pc_low_i  (pc_q[BYTE_W-1:0]),
    .hold_hi_i (hold_hi),
    .hold_up_i (hold_up),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (src != SRC_HOLD) begin
      pc_q <= pc_d;
    end
  end

  assign fetch_addr_o = pc_q;

endmodule

// File: rtl/pc_latched_upper_chk.sv
module pc_latched_upper_chk #(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8,
  parameter int STEP   = 2,
  parameter int VEC_HI = 8,
  parameter int VEC_LO = 24,
  localparam int UP_W  = ADDR_W - 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              jmp_load_i,
  input logic [ADDR_W-1:0] jmp_target_i,
  input logic              ret_load_i,
  input logic [ADDR_W-1:0] ret_addr_i,
  input logic              irq_ack_i,
  input logic              irq_hi_i,
  input logic [1:0]        reg_sel_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [BYTE_W-1:0] hold_hi,
  input logic [UP_W-1:0]   hold_up
);

  logic low_wr;
  logic low_rd;
  assign low_wr = reg_wr_i && (reg_sel_i == 2'b00);
  assign low_rd = reg_rd_i && (reg_sel_i == 2'b00);

  p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr_o[0] == 1'b0);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !irq_ack_i && !jmp_load_i && !ret_load_i && !low_wr)
    |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(STEP));

  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> fetch_addr_o ==
      ($past(irq_hi_i) ? ADDR_W'(VEC_HI) : ADDR_W'(VEC_LO)));

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_load_i && !irq_ack_i)
    |=> fetch_addr_o == {$past(jmp_target_i[ADDR_W-1:1]), 1'b0});

  p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_load_i && !jmp_load_i && !irq_ack_i)
    |=> fetch_addr_o == {$past(ret_addr_i[ADDR_W-1:1]), 1'b0});

  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_i && !reg_rd_i) |=> ($stable(hold_hi) && $stable(hold_up)));

  p_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> (hold_hi == $past(fetch_addr_o[2*BYTE_W-1:BYTE_W]) &&
                hold_up == $past(fetch_addr_o[ADDR_W-1:2*BYTE_W])));

  p_low_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && !irq_ack_i && !jmp_load_i && !ret_load_i)
    |=> fetch_addr_o == {$past(hold_up), $past(hold_hi),
                         $past(reg_wdata_i[BYTE_W-1:1]), 1'b0});

endmodule

bind pc_latched_upper pc_latched_upper_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STEP(STEP),
  .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adv_i        (adv_i),
  .jmp_load_i   (jmp_load_i),
  .jmp_target_i (jmp_target_i),
  .ret_load_i   (ret_load_i),
  .ret_addr_i   (ret_addr_i),
  .irq_ack_i    (irq_ack_i),
  .irq_hi_i     (irq_hi_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_wdata_i  (reg_wdata_i),
  .fetch_addr_o (fetch_addr_o),
  .hold_hi      (hold_hi),
  .hold_up      (hold_up)
);

// File: tb/test_pc_latched_upper.sv
module test_pc_latched_upper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 1'b0;
  logic        jmp_load_i = 1'b0;
  logic [20:0] jmp_target_i = '0;
  logic        ret_load_i = 1'b0;
  logic [20:0] ret_addr_i = '0;
  logic        irq_ack_i = 1'b0;
  logic        irq_hi_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'b11;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [20:0] fetch_addr_o;
  logic [7:0]  reg_rdata_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pc_latched_upper i_pc_latched_upper (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i),
    .jmp_load_i(jmp_load_i), .jmp_target_i(jmp_target_i),
    .ret_load_i(ret_load_i), .ret_addr_i(ret_addr_i),
    .irq_ack_i(irq_ack_i), .irq_hi_i(irq_hi_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .fetch_addr_o(fetch_addr_o),
    .reg_rdata_o(reg_rdata_o)
  );

  // Op codes for the vector table
  localparam logic [3:0] OP_ADV = 4'd0, OP_JMP = 4'd1, OP_RET = 4'd2,
    OP_IRQH = 4'd3, OP_IRQL = 4'd4, OP_WRL = 4'd5, OP_WRH = 4'd6, OP_WRU = 4'd7;

  // {op, argument, expected fetch address after the edge}
  localparam int NVEC = 15;
  localparam logic [45:0] VEC [NVEC] = '{
    {OP_ADV,  21'h000000, 21'h000002},  // R2
    {OP_ADV,  21'h000000, 21'h000004},  // R2
    {OP_JMP,  21'h001A35, 21'h001A34},  // R3 bit 0 cleared
    {OP_ADV,  21'h000000, 21'h001A36},  // R2
    {OP_WRH,  21'h00000D, 21'h001A36},  // R8 no counter change
    {OP_WRU,  21'h000001, 21'h001A36},  // R8
    {OP_WRL,  21'h000059, 21'h010D58},  // R6 latches committed
    {OP_RET,  21'h000105, 21'h000104},  // R4
    {OP_WRL,  21'h000020, 21'h010D20},  // R4 latches intact after return
    {OP_IRQH, 21'h000000, 21'h000008},  // R5
    {OP_IRQL, 21'h000000, 21'h000018},  // R5
    {OP_JMP,  21'h1FFFFE, 21'h1FFFFE},  // R3
    {OP_ADV,  21'h000000, 21'h000000},  // R2 wrap
    {OP_WRU,  21'h0000FF, 21'h000000},  // R8
    {OP_WRL,  21'h000000, 21'h1F0D00}   // R6 upper latch holds 5 bits
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    adv_i = 0; jmp_load_i = 0; ret_load_i = 0; irq_ack_i = 0;
    reg_wr_i = 0; reg_rd_i = 0; reg_sel_i = 2'b11;
  endtask

  task automatic edge_then_idle();
    @(posedge clk);
    #2;
    idle();
  endtask

  task automatic apply(input logic [3:0] op, input logic [20:0] arg);
    case (op)
      OP_ADV:  adv_i = 1;
      OP_JMP:  begin jmp_load_i = 1; jmp_target_i = arg; end
      OP_RET:  begin ret_load_i = 1; ret_addr_i = arg; end
      OP_IRQH: begin irq_ack_i = 1; irq_hi_i = 1; end
      OP_IRQL: begin irq_ack_i = 1; irq_hi_i = 0; end
      OP_WRL:  begin reg_wr_i = 1; reg_sel_i = 2'b00; reg_wdata_i = arg[7:0]; end
      OP_WRH:  begin reg_wr_i = 1; reg_sel_i = 2'b01; reg_wdata_i = arg[7:0]; end
      default: begin reg_wr_i = 1; reg_sel_i = 2'b10; reg_wdata_i = arg[7:0]; end
    endcase
    edge_then_idle();
  endtask

  task automatic read_reg(input logic [1:0] s, input string req,
                          input logic [7:0] exp);
    reg_sel_i = s;
    #1;
    check(req, {24'h0, reg_rdata_o}, {24'h0, exp});
    reg_sel_i = 2'b11;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 reset fetch", {11'h0, fetch_addr_o}, 32'h0);
    read_reg(2'b01, "R1 high latch reset", 8'h00);
    read_reg(2'b10, "R1 upper latch reset", 8'h00);
    rst_n = 1;
    @(posedge clk);
    #2;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][45:42], VEC[i][41:21]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i),
            {11'h0, fetch_addr_o}, {11'h0, VEC[i][20:0]});
      check("R10 bit0", {31'h0, fetch_addr_o[0]}, 32'h0);
    end

    // R8 latch readback, upper pads with zeros, unused select reads 0
    read_reg(2'b10, "R8 upper latch readback", 8'h1F);
    read_reg(2'b01, "R8 high latch readback", 8'h0D);
    read_reg(2'b11, "R8 unused select", 8'h00);
    reg_wr_i = 1; reg_sel_i = 2'b11; reg_wdata_i = 8'hAA;
    edge_then_idle();
    read_reg(2'b01, "R8 unused write ignored hi", 8'h0D);
    read_reg(2'b10, "R8 unused write ignored up", 8'h1F);
    check("R8 unused write fetch", {11'h0, fetch_addr_o}, 32'h1F0D00);

    // R7 snapshot
    apply(OP_JMP, 21'h15A7C4);
    read_reg(2'b00, "R7 low byte read", 8'hC4);
    reg_sel_i = 2'b00; reg_rd_i = 1;
    edge_then_idle();
    read_reg(2'b01, "R7 snapshot high", 8'hA7);
    read_reg(2'b10, "R7 snapshot upper", 8'h15);
    apply(OP_ADV, 21'h0);
    apply(OP_WRL, 21'h000010);
    check("R7 snapshot committed", {11'h0, fetch_addr_o}, 32'h15A710);

    // R7 with carry-producing advance in the same cycle
    apply(OP_JMP, 21'h02FFFE);
    reg_sel_i = 2'b00; reg_rd_i = 1; adv_i = 1;
    edge_then_idle();
    check("R7 advance with read", {11'h0, fetch_addr_o}, 32'h030000);
    read_reg(2'b01, "R7 pre-edge high", 8'hFF);
    read_reg(2'b10, "R7 pre-edge upper", 8'h02);

    // R9 low-byte write loses to a jump and is dropped
    jmp_load_i = 1; jmp_target_i = 21'h004444;
    reg_wr_i = 1; reg_sel_i = 2'b00; reg_wdata_i = 8'h66;
    edge_then_idle();
    check("R9 jump over low write", {11'h0, fetch_addr_o}, 32'h004444);
    read_reg(2'b01, "R9 latches untouched hi", 8'hFF);
    read_reg(2'b10, "R9 latches untouched up", 8'h02);

    // R9 low write over advance
    adv_i = 1; reg_wr_i = 1; reg_sel_i = 2'b00; reg_wdata_i = 8'h30;
    edge_then_idle();
    check("R9 low write over advance", {11'h0, fetch_addr_o}, 32'h02FF30);

    // R9 interrupt over jump
    irq_ack_i = 1; irq_hi_i = 0; jmp_load_i = 1; jmp_target_i = 21'h000100;
    edge_then_idle();
    check("R9 interrupt over jump", {11'h0, fetch_addr_o}, 32'h000018);

    // R4 jump over return
    jmp_load_i = 1; jmp_target_i = 21'h000200;
    ret_load_i = 1; ret_addr_i = 21'h000300;
    edge_then_idle();
    check("R4 jump over return", {11'h0, fetch_addr_o}, 32'h000200);

    // R1 reset over a jump
    jmp_load_i = 1; jmp_target_i = 21'h000400; rst_n = 0;
    edge_then_idle();
    check("R1 reset over jump", {11'h0, fetch_addr_o}, 32'h0);
    read_reg(2'b01, "R1 reset clears high latch", 8'h00);
    rst_n = 1;
    @(posedge clk);
    #2;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

endmodule